// File: doc/BRIEF.md
# External Interrupt Trigger Conditioner

This block turns a set of asynchronous external interrupt pins into clean, active-high level requests for a vectored interrupt controller that only understands high-level triggers. Every channel carries its own 2-bit trigger selection. Two of the settings are level triggers, one for high and one for low. The other two are edge triggers, one for rising and one for falling. In both level settings the request is active high.

In the level settings the request tracks the synchronized pin. It is inverted when the channel is set for low-level triggering. In the edge settings a detected transition sets a sticky flag. The flag drives the request until software writes a one to that channel's clear bit. Software programs all channels at once through a single mode-vector write. A write that changes a channel's setting discards any pending edge on that channel. Prioritising and vectoring the requests are left to the downstream controller.

Top module: `extint_conditioner`

## Requirements
- R1: The default build has eight channels. Pin activity, clear bits and mode changes on one channel never alter another channel's request.
- R2: While reset is held and after it is released, every channel is in high-level mode (code 00), every edge flag is clear, and every request is low until a pin is seen high.
- R3: In high-level mode (code 00) the request equals the pin value from two clock edges earlier, through a two-flop synchronizer.
- R4: In low-level mode (code 01) the request is the inverse of the pin value from two clock edges earlier.
- R5: In rising-edge mode (code 10) a 0-to-1 transition of the synchronized pin raises the request. The request rises at the third clock edge after the pin changes.
- R6: In falling-edge mode (code 11) a 1-to-0 transition of the synchronized pin raises the request with the same three-edge latency.
- R7: In an edge mode, once the request is raised it stays high whatever the pin does, until it is cleared or the channel's mode changes.
- R8: A one in bit i of the clear input at a clock edge drops channel i's edge request at that edge. Zero bits, and bits of channels without a pending edge, have no effect.
- R9: If a clear for a channel arrives at the same edge as a newly detected edge on that channel, the request stays high.
- R10: A mode write that changes a channel's code clears that channel's pending edge. Rewriting the same code leaves the pending edge in place.
- R11: The mode vector holds channel i's code in bits [2i+1:2i]. A write strobe captures it at one clock edge, and the new mode governs the request from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | NUM_CH | Asynchronous external interrupt pins |
| cfg_we_i | input | 1 | Mode vector write strobe |
| cfg_mode_i | input | 2*NUM_CH | Mode codes, channel i at [2i+1:2i] |
| clr_i | input | NUM_CH | Write-one-to-clear strobes for edge flags |
| irq_req_o | output | NUM_CH | Active-high level requests to the interrupt controller |

## Verification
A channel whose edge flag is wrong shows the fault directly on its request line, either as a request that never rises or as one that never falls. Either shows within one cycle of the faulty update, because the request is taken straight from the flag. A fault in the synchronizer or the previous-sample register shows as a request that is shifted by a cycle, or as an edge detected on the wrong transition. The bench models the pipeline cycle by cycle and compares every channel on every cycle, so a single-cycle slip is caught at the cycle where it appears. Directed sequences pin down the cases where two events fall on the same edge: a clear arriving with a new edge, and a mode change arriving with a pending flag.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_mode_e;

    localparam int MODE_W = 2;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] stage1_o,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage1_o = st_q.s1;
    assign sync_o   = st_q.s2;

endmodule

// File: rtl/extint_mode_reg.sv
module extint_mode_reg
    import extint_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we_i,
    input  logic [NUM_CH*MODE_W-1:0]       cfg_mode_i,
    output logic [NUM_CH-1:0][MODE_W-1:0]  mode_o,
    output logic [NUM_CH-1:0]              chg_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][MODE_W-1:0] mode;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we_i) begin
            for (int i = 0; i < NUM_CH; i++) begin
                st_d.mode[i] = cfg_mode_i[i*MODE_W +: MODE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                st_q.mode[i] <= TRIG_HIGH;
            end
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chg
        assign chg_o[g] = cfg_we_i && (cfg_mode_i[g*MODE_W +: MODE_W] != st_q.mode[g]);

        // R11: a strobed code is the live mode after the next edge
        p_mode_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_we_i |=> mode_o[g] == $past(cfg_mode_i[g*MODE_W +: MODE_W]));

        // R11: without a strobe the mode holds
        p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_we_i |=> $stable(mode_o[g]));
    end

    assign mode_o = st_q.mode;

endmodule

// File: rtl/extint_channel.sv
module extint_channel
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  trig_mode_e mode_i,
    input  logic       mode_chg_i,
    input  logic       clr_i,
    output logic       req_o
);

    typedef struct packed {
        logic prev;
        logic flag;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     is_edge_mode;
    logic     edge_evt;

    always_comb begin
        is_edge_mode = mode_i[1];
        unique case (mode_i)
            TRIG_RISE: edge_evt = sync_i & ~st_q.prev;
            TRIG_FALL: edge_evt = ~sync_i & st_q.prev;
            default:   edge_evt = 1'b0;
        endcase

        st_d      = st_q;
        st_d.prev = sync_i;
        if (!is_edge_mode || mode_chg_i) begin
            st_d.flag = 1'b0;
        end else if (edge_evt) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end

        unique case (mode_i)
            TRIG_HIGH: req_o = sync_i;
            TRIG_LOW:  req_o = ~sync_i;
            default:   req_o = st_q.flag;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: rising transition seen in rising mode raises the request
    p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_RISE && !mode_chg_i && sync_i && !st_q.prev) |=> req_o);

    // R6: falling transition seen in falling mode raises the request
    p_fall_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_FALL && !mode_chg_i && !sync_i && st_q.prev) |=> req_o);

    // R7: a raised edge request holds without clear or mode change
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge_mode && req_o && !clr_i && !mode_chg_i) |=> req_o);

    // R8: clear with no new edge drops the request
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge_mode && clr_i && !edge_evt && !mode_chg_i) |=> !req_o);

    // R9: a new edge wins over a simultaneous clear
    p_edge_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge_mode && clr_i && edge_evt && !mode_chg_i) |=> req_o);

    // R10: a changed mode leaves no pending edge
    p_chg_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg_i |=> !st_q.flag);

endmodule

// File: rtl/extint_conditioner.sv
module extint_conditioner
    import extint_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          irq_pin_i,
    input  logic                       cfg_we_i,
    input  logic [NUM_CH*MODE_W-1:0]   cfg_mode_i,
    input  logic [NUM_CH-1:0]          clr_i,
    output logic [NUM_CH-1:0]          irq_req_o
);

    logic [NUM_CH-1:0]             pin_s1;
    logic [NUM_CH-1:0]             pin_sync;
    logic [NUM_CH-1:0][MODE_W-1:0] mode_q;
    logic [NUM_CH-1:0]             mode_chg;

    extint_sync #(
        .WIDTH (NUM_CH)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_i  (irq_pin_i),
        .stage1_o (pin_s1),
        .sync_o   (pin_sync)
    );

    extint_mode_reg #(
        .NUM_CH (NUM_CH)
    ) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we_i),
        .cfg_mode_i (cfg_mode_i),
        .mode_o     (mode_q),
        .chg_o      (mode_chg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        extint_channel u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_i     (pin_sync[g]),
            .mode_i     (trig_mode_e'(mode_q[g])),
            .mode_chg_i (mode_chg[g]),
            .clr_i      (clr_i[g]),
            .req_o      (irq_req_o[g])
        );

        // R3: high-level request follows the first sync stage one edge later
        p_level_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[g] == TRIG_HIGH && !cfg_we_i) |=> irq_req_o[g] == $past(pin_s1[g]));

        // R4: low-level request is the inverted first stage one edge later
        p_level_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[g] == TRIG_LOW && !cfg_we_i) |=> irq_req_o[g] == !$past(pin_s1[g]));
    end

    // R2: first cycle out of reset presents no request
    p_reset_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_req_o == '0);

endmodule

// File: tb/tb_extint_conditioner.sv
module tb_extint_conditioner;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   pin = '0;
    logic           we = 1'b0;
    logic [2*N-1:0] mode_w = '0;
    logic [N-1:0]   clr = '0;
    logic [N-1:0]   req;

    int n_chk = 0;
    int n_bad = 0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    extint_conditioner #(.NUM_CH(N)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pin_i  (pin),
        .cfg_we_i   (we),
        .cfg_mode_i (mode_w),
        .clr_i      (clr),
        .irq_req_o  (req)
    );

    // Reference model built from the requirements
    logic [N-1:0]      m_s1, m_s2, m_prev, m_flag;
    logic [N-1:0][1:0] m_mode;

    function automatic logic next_flag(input logic [1:0] md, input logic s2, input logic pv,
                                       input logic fl, input logic chg, input logic cl);
        logic ev;
        ev = (md == 2'b10) ? (s2 & ~pv) : (md == 2'b11) ? (~s2 & pv) : 1'b0;
        if (!md[1] || chg) return 1'b0;
        if (ev)            return 1'b1;
        if (cl)            return 1'b0;
        return fl;
    endfunction

    function automatic logic exp_req(input logic [1:0] md, input logic s2, input logic fl);
        if (md[1]) return fl;
        return s2 ^ md[0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_flag <= '0; m_mode <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                logic chg;
                chg = we && (mode_w[2*i +: 2] != m_mode[i]);
                m_flag[i] <= next_flag(m_mode[i], m_s2[i], m_prev[i], m_flag[i], chg, clr[i]);
                if (we) m_mode[i] <= mode_w[2*i +: 2];
            end
            m_s1   <= pin;
            m_s2   <= m_s1;
            m_prev <= m_s2;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison of every channel, away from the active edge
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            for (int i = 0; i < N; i++) begin
                logic e;
                string tg;
                e = exp_req(m_mode[i], m_s2[i], m_flag[i]);
                case (m_mode[i])
                    2'b00:   tg = "R3 model ch";
                    2'b01:   tg = "R4 model ch";
                    2'b10:   tg = "R5/R7 model ch";
                    default: tg = "R6/R7 model ch";
                endcase
                check(req[i] === e, $sformatf("%s%0d (R1)", tg, i), {31'd0, req[i]}, {31'd0, e});
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [2*N-1:0] v);
        mode_w = v; we = 1'b1;
        cyc(1);
        we = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        cyc(3);
        check(req === '0, "R2 during reset", req, 0);
        rst_n = 1'b1;
        cyc(1);
        model_on = 1'b1;
        check(req === '0, "R2 after reset", req, 0);

        // R2/R3: default mode is high level, two-edge latency
        pin[0] = 1'b1;
        cyc(1);
        check(req[0] === 1'b0, "R3 one edge too early", req[0], 0);
        cyc(1);
        check(req[0] === 1'b1, "R2 R3 high level", req[0], 1);
        pin[0] = 1'b0;
        cyc(2);
        check(req[0] === 1'b0, "R3 high level drop", req[0], 0);

        // R11: all channels rising edge
        wr_mode(16'hAAAA);
        cyc(2);
        pin[5] = 1'b1;
        cyc(3);
        check(req[5] === 1'b1, "R5 ch5 rising", req[5], 1);
        pin[3] = 1'b1;
        cyc(2);
        check(req[3] === 1'b0, "R5 latency two edges", req[3], 0);
        cyc(1);
        check(req[3] === 1'b1, "R5 latency three edges", req[3], 1);
        pin[3] = 1'b0;
        cyc(4);
        check(req[3] === 1'b1, "R7 sticky after pin drop", req[3], 1);

        // R8: clear ch3 and an idle ch6, ch5 untouched
        clr = 8'h48;
        cyc(1);
        clr = '0;
        check(req[3] === 1'b0, "R8 clear ch3", req[3], 0);
        check(req[5] === 1'b1, "R1 R8 ch5 unaffected", req[5], 1);
        check(req[6] === 1'b0, "R8 idle clear no effect", req[6], 0);

        // R9: clear coincident with new edge
        pin[3] = 1'b1;
        cyc(2);
        clr = 8'h08;
        cyc(1);
        clr = '0;
        check(req[3] === 1'b1, "R9 edge beats clear", req[3], 1);

        // R10: same-code rewrite keeps flags, changed code clears
        wr_mode(16'hAAAA);
        check(req[3] === 1'b1, "R10 same code keeps ch3", req[3], 1);
        check(req[5] === 1'b1, "R10 same code keeps ch5", req[5], 1);
        wr_mode(16'hAAEA);
        check(req[3] === 1'b0, "R10 changed code clears ch3", req[3], 0);
        check(req[5] === 1'b1, "R1 R10 ch5 kept", req[5], 1);

        // R6: falling edge on ch3
        pin[3] = 1'b0;
        cyc(2);
        check(req[3] === 1'b0, "R6 latency two edges", req[3], 0);
        cyc(1);
        check(req[3] === 1'b1, "R6 falling sets", req[3], 1);

        // R4/R11: ch1 low level, pin1 low
        wr_mode(16'hAAE6);
        check(req[1] === 1'b1, "R4 R11 low level active", req[1], 1);
        pin[1] = 1'b1;
        cyc(1);
        check(req[1] === 1'b1, "R4 sync latency", req[1], 1);
        cyc(1);
        check(req[1] === 1'b0, "R4 low level released", req[1], 0);

        // Constrained random phase, checked by the model every cycle
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] flip;
            for (int b = 0; b < N; b++) flip[b] = ($urandom % 4) == 0;
            pin = pin ^ flip;
            clr = N'($urandom & $urandom & $urandom);
            if (($urandom % 40) == 0) begin
                mode_w = 16'($urandom);
                we = 1'b1;
            end else begin
                we = 1'b0;
            end
            cyc(1);
        end
        we = 1'b0; clr = '0;
        cyc(4);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule